// File: doc/BRIEF.md
# Multi-channel prescaled reload timer

This block holds several independent down-counting timer channels, three by default, each 32 bits wide. Every channel draws its count rate from the peripheral clock through its own prescaler. When a channel's count is at zero and another tick arrives, the channel reloads from its reload-value register. It also raises a sticky underflow flag, and it can turn that flag into an interrupt request.

Software reaches the block through a simple word-addressed register port. Writes are strobed and reads are combinational. Word 0 is a shared run register with one start bit per channel. Each channel n then takes three words: a control word at 1+3n, a reload value at 2+3n and the live count at 3+3n. Every register can be both read and written.

Top module: `multi_reload_timer`

## Requirements
- R1: Bit n of the run register (word 0) starts channel n. While that bit is 0, the channel's count holds its value.
- R2: Control bits [2:0] select the prescale ratio: 0 gives /16, 1 gives /64, 2 gives /256, 3 gives /1024 and 4 gives /4096. After a start, the count first changes exactly that many clocks after the run bit is written.
- R3: Select values 5, 6 and 7 make the channel tick on every clock, so the count changes one clock after the start.
- R4: Each tick of a started channel lowers its count by exactly one.
- R5: A tick that arrives while the count is 0 loads the reload value instead of decrementing. Counting then carries on down from the reloaded value.
- R6: That reload event sets the flag in control bit 8, and the flag stays set afterwards.
- R7: Writing a control word with bit 8 at 0 clears the flag. Writing 1 to bit 8 never sets the flag. A clearing write in the same clock as a reload event leaves the flag set.
- R8: irq_o[n] is high exactly when channel n's flag and its control bit 5 are both 1.
- R9: A bus write to a count word wins over a decrement or reload in the same clock.
- R10: Stopping a channel clears its prescaler. After a restart, the first tick comes one full prescale period later.
- R11: After reset, every register reads 0, including a prescale select of 0 (/16), and irq_o is 0.
- R12: Control words read back {flag at bit 8, interrupt enable at bit 5, select at [2:0]}, with all other bits 0. Reload and count words read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the addressed word |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data for reg_addr_i, combinational |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
The hardest case to reach is a clearing write to the flag that lands on the same clock as a reload. With the count and the reload value both 0 and a divide-by-1 select, the channel reloads on every clock. Any control write issued while that channel runs therefore collides with a reload event, and the flag must read back as set. Prescaler clearing is checked another way: the channel is stopped part way through a /16 period and restarted, and the bench confirms that the first decrement comes a full 16 clocks after the restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W     = 12;
  localparam int SEL_W     = 3;
  localparam int IE_BIT    = 5;
  localparam int FLAG_BIT  = 8;
  localparam int REGS_PER_CH = 3;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  // log2 of the prescale ratio; 0 means every clock
  function automatic int unsigned pre_shift(input logic [SEL_W-1:0] sel);
    if (sel <= 3'd4) return 4 + 2 * int'(sel);
    return 0;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] term;

  always_comb begin
    term   = PRE_W'((32'd1 << pre_shift(sel_i)) - 32'd1);
    tick_o = run_i && (cnt_q >= term);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && term != '0) ##1 $stable(sel_i) |-> !tick_o); // R2
  AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_i) && term != '0) |-> !tick_o); // R10
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             we_ctrl_i,
  input  logic             we_const_i,
  input  logic             we_cnt_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] ctrl_rd_o,
  output logic [CNT_W-1:0] const_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] const_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             uf;

  tmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .sel_i  (ctrl_q.sel),
    .tick_o (tick)
  );

  assign uf = tick && (cnt_q == '0) && !we_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      const_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (we_ctrl_i) begin
        ctrl_q.sel <= wdata_i[SEL_W-1:0];
        ctrl_q.ie  <= wdata_i[IE_BIT];
      end
      if (uf)                                ctrl_q.flag <= 1'b1;
      else if (we_ctrl_i && !wdata_i[FLAG_BIT]) ctrl_q.flag <= 1'b0;
      if (we_const_i) const_q <= wdata_i;
      if (we_cnt_i)       cnt_q <= wdata_i;
      else if (uf)        cnt_q <= const_q;
      else if (tick)      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    ctrl_rd_o                = '0;
    ctrl_rd_o[SEL_W-1:0]     = ctrl_q.sel;
    ctrl_rd_o[IE_BIT]        = ctrl_q.ie;
    ctrl_rd_o[FLAG_BIT]      = ctrl_q.flag;
  end
  assign const_o = const_q;
  assign cnt_o   = cnt_q;
  assign irq_o   = ctrl_q.flag & ctrl_q.ie;

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_cnt_i) |=> $stable(cnt_o)); // R1
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_o != '0 && !we_cnt_i) |=> cnt_o == $past(cnt_o) - 1'b1); // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_o == '0 && !we_cnt_i) |=> cnt_o == $past(const_o)); // R5
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_o == '0 && !we_cnt_i) |=> ctrl_rd_o[FLAG_BIT]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_o[FLAG_BIT] && !(we_ctrl_i && !wdata_i[FLAG_BIT])) |=> ctrl_rd_o[FLAG_BIT]); // R6
  AST_FLAG_NO_SET_BY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rd_o[FLAG_BIT] && !tick) |=> !ctrl_rd_o[FLAG_BIT]); // R7
  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_cnt_i |=> cnt_o == $past(wdata_i)); // R9
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CNT_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ctrl_rd_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] const_rd_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_rd_i,
  output logic [NUM_CH-1:0]            run_o,
  output logic [NUM_CH-1:0]            we_ctrl_o,
  output logic [NUM_CH-1:0]            we_const_o,
  output logic [NUM_CH-1:0]            we_cnt_o,
  output logic [CNT_W-1:0]             rdata_o
);
  logic [NUM_CH-1:0] run_q;
  logic [NUM_CH-1:0] hit_ctrl, hit_const, hit_cnt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam int BASE = 1 + REGS_PER_CH * c;
    assign hit_ctrl[c]   = (int'(addr_i) == BASE);
    assign hit_const[c]  = (int'(addr_i) == BASE + 1);
    assign hit_cnt[c]    = (int'(addr_i) == BASE + 2);
    assign we_ctrl_o[c]  = we_i && hit_ctrl[c];
    assign we_const_o[c] = we_i && hit_const[c];
    assign we_cnt_o[c]   = we_i && hit_cnt[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (we_i && addr_i == '0)   run_q <= wdata_i[NUM_CH-1:0];
  end
  assign run_o = run_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[NUM_CH-1:0] = run_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_ctrl[c])  rdata_o = ctrl_rd_i[c];
      if (hit_const[c]) rdata_o = const_rd_i[c];
      if (hit_cnt[c])   rdata_o = cnt_rd_i[c];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_ctrl_o, we_const_o, we_cnt_o})); // R12
  AST_RUN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> run_o == $past(wdata_i[NUM_CH-1:0])); // R1
endmodule

// File: rtl/multi_reload_timer.sv
module multi_reload_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = $clog2(1 + REGS_PER_CH * NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0]            run, we_ctrl, we_const, we_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] ctrl_rd, const_rd, cnt_rd;

  tmr_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .ctrl_rd_i  (ctrl_rd),
    .const_rd_i (const_rd),
    .cnt_rd_i   (cnt_rd),
    .run_o      (run),
    .we_ctrl_o  (we_ctrl),
    .we_const_o (we_const),
    .we_cnt_o   (we_cnt),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run[c]),
      .we_ctrl_i  (we_ctrl[c]),
      .we_const_i (we_const[c]),
      .we_cnt_i   (we_cnt[c]),
      .wdata_i    (reg_wdata_i),
      .ctrl_rd_o  (ctrl_rd[c]),
      .const_o    (const_rd[c]),
      .cnt_o      (cnt_rd[c]),
      .irq_o      (irq_o[c])
    );
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> ($past(we_ctrl[0]) || $past(run[0]))); // R8
endmodule

// File: tb/tb_multi_reload_timer.sv
module tb_multi_reload_timer;
  localparam int NCH = 3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  multi_reload_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [3:0] a_ctrl(int c);  return 4'(1 + 3*c); endfunction
  function automatic logic [3:0] a_const(int c); return 4'(2 + 3*c); endfunction
  function automatic logic [3:0] a_cnt(int c);   return 4'(3 + 3*c); endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  // driver: expected value of a word one clock on
  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(posedge clk); #1 addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic chk_irq(input logic [31:0] e, input string t);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {29'b0, irq} : rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic test_div(input int c, input logic [2:0] sel, input int per, input string t);
    wr(4'd0, 32'd0);
    wr(a_ctrl(c), {29'b0, sel});
    wr(a_cnt(c), 32'd20);
    wr(4'd0, 32'(1 << c));
    if (per == 1) begin
      chk(a_cnt(c), 32'd19, t);
    end else begin
      repeat (per - 2) @(posedge clk);
      chk(a_cnt(c), 32'd20, t);
      chk(a_cnt(c), 32'd19, t);
    end
    wr(4'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    chk(4'd0, 32'd0, "R11");
    for (int c = 0; c < NCH; c++) begin
      chk(a_ctrl(c), 32'd0, "R11");
      chk(a_cnt(c), 32'd0, "R11");
    end
    chk_irq(32'd0, "R11");
    // R12 readback
    wr(a_const(0), 32'h1234_5678); chk(a_const(0), 32'h1234_5678, "R12");
    wr(a_cnt(1), 32'hDEAD_BEEF);   chk(a_cnt(1), 32'hDEAD_BEEF, "R12");
    wr(a_ctrl(2), 32'hFFFF_FFFF);  chk(a_ctrl(2), 32'h0000_0027, "R12 R7");
    wr(a_ctrl(2), 32'd0);
    // R2 / R3 prescale ratios
    test_div(0, 3'd0, 16,   "R2");
    test_div(0, 3'd1, 64,   "R2");
    test_div(1, 3'd2, 256,  "R2");
    test_div(2, 3'd3, 1024, "R2");
    test_div(0, 3'd4, 4096, "R2");
    test_div(0, 3'd5, 1, "R3");
    test_div(1, 3'd6, 1, "R3");
    test_div(2, 3'd7, 1, "R3");
    // R4 R5 R6 reload and flag
    wr(a_ctrl(0), 32'h005); wr(a_cnt(0), 32'd2); wr(a_const(0), 32'd4);
    wr(4'd0, 32'd1);
    chk(a_cnt(0), 32'd1, "R4");
    chk(a_cnt(0), 32'd0, "R4");
    chk(a_cnt(0), 32'd4, "R5");
    chk(a_cnt(0), 32'd3, "R5");
    chk(a_ctrl(0), 32'h105, "R6");
    wr(4'd0, 32'd0);
    chk(a_ctrl(0), 32'h105, "R6");
    // R8 interrupt, R7 clear
    chk_irq(32'd0, "R8");
    wr(a_ctrl(0), 32'h125);
    chk_irq(32'd1, "R8");
    chk(a_ctrl(0), 32'h125, "R7");
    wr(a_ctrl(0), 32'h025);
    chk(a_ctrl(0), 32'h025, "R7");
    chk_irq(32'd0, "R8");
    // R7 clear collides with reload
    wr(a_ctrl(0), 32'h005); wr(a_cnt(0), 32'd0); wr(a_const(0), 32'd0);
    wr(4'd0, 32'd1);
    wr(a_ctrl(0), 32'h005);
    chk(a_ctrl(0), 32'h105, "R7");
    wr(4'd0, 32'd0);
    wr(a_ctrl(0), 32'h005);
    chk(a_ctrl(0), 32'h005, "R7");
    // R9 write priority, then R1 hold
    wr(a_const(0), 32'd50);
    wr(4'd0, 32'd1);
    wr(a_cnt(0), 32'd100);
    chk(a_cnt(0), 32'd99, "R9");
    chk(a_cnt(0), 32'd98, "R9");
    wr(4'd0, 32'd0);
    chk(a_cnt(0), 32'd96, "R1");
    repeat (10) @(posedge clk);
    chk(a_cnt(0), 32'd96, "R1");
    // R10 prescaler cleared on stop
    wr(a_ctrl(0), 32'h000); wr(a_cnt(0), 32'd20);
    wr(4'd0, 32'd1);
    repeat (10) @(posedge clk);
    wr(4'd0, 32'd0);
    chk(a_cnt(0), 32'd20, "R10");
    wr(4'd0, 32'd1);
    repeat (14) @(posedge clk);
    chk(a_cnt(0), 32'd20, "R10");
    chk(a_cnt(0), 32'd19, "R10");
    wr(4'd0, 32'd0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule